// File: doc/BRIEF.md
# Machine status and ISA-extension legal-value registers

This block holds the machine status register and the ISA-extension register of a hart. It also gives the supervisor a masked view of the status register. Each register accepts any value on a write but keeps only a legal one. Status writes change only the fields that the hart implements. The summary-dirty bit at the top of the status word is recomputed from the floating-point and extension state fields after every write. A one-cycle pulse tells the address-translation logic to flush whenever a write changes a field that affects translation.

ISA-extension writes are checked as a whole. A write that would leave neither a base integer set nor allow only the embedded base is discarded. A write that is kept is pruned: unsupported letters are removed, double precision is removed without single precision, and compressed is removed when the next instruction address is not word aligned. The machine-width field is never altered.

The write port is a plain register select, a write strobe and write data. It takes a write on every clock edge where the strobe is high, so there is no back-pressure. The three register values are always present on the read outputs.

Top module: `mstatus_isa_warl`

## Requirements
- R1: After reset the status register reads 0 and the ISA register reads the legal form of the supported mask (default 0x4014112D), with the machine-width field [XLEN-1:XLEN-2] set to 1 for XLEN 32.
- R2: A status write (sel 0) replaces only the writable bits, mask 0x007E79AA: bit 1, bit 3, bit 5, bit 7, bit 8, bits 12:11, bits 14:13, and bits 22:17. Every other bit keeps its old value.
- R3: After every write, status bit XLEN-1 is 1 when bits 14:13 are 2'b11 or bits 16:15 are 2'b11, and 0 otherwise.
- R4: flush_o is high for exactly the one cycle after a status or supervisor write that changes any of bits 12:11, 17, 18 or 19. It stays low at every other time.
- R5: sstatus_o equals the status register ANDed with 0x800DE133.
- R6: A supervisor write (sel 1) first merges the write data into the status value under mask 0x800DE133. The result then passes through the R2/R3 status write path.
- R7: An ISA write (sel 2) is discarded when bit 4 (E) is set, or when both bit 8 (I) and bit 4 are clear.
- R8: A kept ISA write is ANDed with the supported mask and with the letter set A(0), C(2), D(3), E(4), F(5), I(8), M(12), S(18), U(20).
- R9: A kept ISA write clears bit 3 (D) when bit 5 (F) is clear.
- R10: A kept ISA write clears bit 2 (C) when next_pc_lsb is not 2'b00.
- R11: The machine-width field [XLEN-1:XLEN-2] of the ISA register never changes on a write.
- R12: Nothing changes and flush_o stays low when wr_en is low or when sel is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Target: 0 status, 1 supervisor view, 2 ISA, 3 none |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | XLEN | Write data |
| next_pc_lsb | input | 2 | Low bits of the next instruction address |
| mstatus_o | output | XLEN | Machine status value |
| sstatus_o | output | XLEN | Supervisor view of status |
| isa_o | output | XLEN | ISA-extension value |
| flush_o | output | 1 | One-cycle translation-flush pulse |

## Verification
A write is taken at the rising edge where wr_en is high. All three register values change at that edge, and flush_o rises at the same edge, so every result is due one cycle after the stimulus is presented. flush_o is due to fall again one cycle later. The driver builds the expected item just after that rising edge, and the monitor compares it at the following falling edge. An idle cycle after each write item lets the bench check both that the flush pulse has fallen and that the values are held.

// File: rtl/mstat_isa_pkg.sv
package mstat_isa_pkg;

  typedef enum logic [1:0] {
    SEL_MSTAT = 2'd0,
    SEL_SVIEW = 2'd1,
    SEL_ISA   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // status field positions
  localparam int B_UIE  = 0;
  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_UPIE = 4;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_MPP  = 11;
  localparam int B_FS   = 13;
  localparam int B_XS   = 15;
  localparam int B_MPRV = 17;
  localparam int B_SUM  = 18;
  localparam int B_MXR  = 19;
  localparam int B_TVM  = 20;
  localparam int B_TSR  = 21;
  localparam int B_TW   = 22;

  // extension letter positions
  localparam int X_A = 0;
  localparam int X_C = 2;
  localparam int X_D = 3;
  localparam int X_E = 4;
  localparam int X_F = 5;
  localparam int X_I = 8;
  localparam int X_M = 12;
  localparam int X_S = 18;
  localparam int X_U = 20;

  function automatic logic [63:0] one_at(int pos);
    return 64'd1 << pos;
  endfunction

  function automatic logic [63:0] status_wr_mask();
    return one_at(B_SIE) | one_at(B_MIE) | one_at(B_SPIE) | one_at(B_MPIE) |
           one_at(B_SPP) | (64'd3 << B_MPP) | (64'd3 << B_FS) |
           one_at(B_MPRV) | one_at(B_SUM) | one_at(B_MXR) |
           one_at(B_TVM) | one_at(B_TSR) | one_at(B_TW);
  endfunction

  function automatic logic [63:0] sview_mask(int xlen);
    return one_at(B_UIE) | one_at(B_SIE) | one_at(B_UPIE) | one_at(B_SPIE) |
           one_at(B_SPP) | (64'd3 << B_FS) | (64'd3 << B_XS) |
           one_at(B_SUM) | one_at(B_MXR) | one_at(xlen - 1);
  endfunction

  function automatic logic [63:0] xlate_mask();
    return (64'd3 << B_MPP) | one_at(B_MPRV) | one_at(B_SUM) | one_at(B_MXR);
  endfunction

  function automatic logic [63:0] isa_letters();
    return one_at(X_A) | one_at(X_C) | one_at(X_D) | one_at(X_E) | one_at(X_F) |
           one_at(X_I) | one_at(X_M) | one_at(X_S) | one_at(X_U);
  endfunction

endpackage

// File: rtl/mstat_merge.sv
module mstat_merge
  import mstat_isa_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur,
  input  logic [XLEN-1:0] wdata,
  input  logic            via_sview,
  output logic [XLEN-1:0] nxt,
  output logic            xlate_chg
);
  localparam logic [XLEN-1:0] WMASK = XLEN'(status_wr_mask());
  localparam logic [XLEN-1:0] SVIEW = XLEN'(sview_mask(XLEN));
  localparam logic [XLEN-1:0] FMASK = XLEN'(xlate_mask());

  logic [XLEN-1:0] merged;

  always_comb begin
    merged = via_sview ? ((cur & ~SVIEW) | (wdata & SVIEW)) : wdata;
    nxt = (cur & ~WMASK) | (merged & WMASK);
    nxt[XLEN-1] = (nxt[B_FS+1:B_FS] == 2'b11) || (nxt[B_XS+1:B_XS] == 2'b11);
    xlate_chg = |((nxt ^ cur) & FMASK);
  end
endmodule

// File: rtl/mstat_unit.sv
module mstat_unit
  import mstat_isa_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_m,
  input  logic            wr_s,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] mstatus,
  output logic [XLEN-1:0] sstatus,
  output logic            flush
);
  localparam logic [XLEN-1:0] SVIEW = XLEN'(sview_mask(XLEN));
  localparam logic [XLEN-1:0] FMASK = XLEN'(xlate_mask());

  logic [XLEN-1:0] mstatus_q, nxt;
  logic            flush_q, chg;
  logic            wr_any;

  assign wr_any = wr_m | wr_s;

  mstat_merge #(.XLEN(XLEN)) u_merge (
    .cur       (mstatus_q),
    .wdata     (wdata),
    .via_sview (wr_s),
    .nxt       (nxt),
    .xlate_chg (chg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mstatus_q <= '0;
      flush_q   <= 1'b0;
    end else begin
      if (wr_any) mstatus_q <= nxt;
      flush_q <= wr_any && chg;
    end
  end

  assign mstatus = mstatus_q;
  assign sstatus = mstatus_q & SVIEW;
  assign flush   = flush_q;

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> ($stable(mstatus_q) && !flush_q));

  assert_sd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> (mstatus_q[XLEN-1] ==
      ((mstatus_q[B_FS+1:B_FS] == 2'b11) || (mstatus_q[B_XS+1:B_XS] == 2'b11))));

  assert_flush_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> (flush_q == (((mstatus_q ^ $past(mstatus_q)) & FMASK) != '0)));
endmodule

// File: rtl/isa_unit.sv
module isa_unit
  import mstat_isa_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] SUPPORTED = XLEN'(32'h0014112D)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [XLEN-1:0] wdata,
  input  logic [1:0]      next_pc_lsb,
  output logic [XLEN-1:0] isa
);
  localparam logic [1:0]      MXL    = (XLEN == 64) ? 2'd2 : 2'd1;
  localparam logic [XLEN-1:0] LEGAL  = SUPPORTED & XLEN'(isa_letters());
  localparam logic [XLEN-1:0] BASE   = LEGAL & ~(XLEN'(1) << X_E);
  localparam logic [XLEN-1:0] RST_LO = (BASE[X_D] && !BASE[X_F]) ?
                                       (BASE & ~(XLEN'(1) << X_D)) : BASE;
  localparam logic [XLEN-1:0] RST_VAL = {MXL, RST_LO[XLEN-3:0]};

  logic [XLEN-1:0] isa_q, pruned;
  logic            drop;

  always_comb begin
    drop = wdata[X_E] || !wdata[X_I];
    pruned = wdata & LEGAL;
    if (pruned[X_D] && !pruned[X_F]) pruned[X_D] = 1'b0;
    if (pruned[X_C] && (next_pc_lsb != 2'b00)) pruned[X_C] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isa_q <= RST_VAL;
    else if (wr && !drop) isa_q <= {isa_q[XLEN-1:XLEN-2], pruned[XLEN-3:0]};
  end

  assign isa = isa_q;

  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (wdata[X_E] || !wdata[X_I])) |=> $stable(isa_q));

  assert_mxl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> $stable(isa_q[XLEN-1:XLEN-2]));

  assert_dep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    isa_q[X_D] |-> isa_q[X_F]);

  assert_calign_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && next_pc_lsb != 2'b00) |=> !isa_q[X_C] || $stable(isa_q));
endmodule

// File: rtl/mstatus_isa_warl.sv
module mstatus_isa_warl
  import mstat_isa_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] SUPPORTED = XLEN'(32'h0014112D)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      sel,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic [1:0]      next_pc_lsb,
  output logic [XLEN-1:0] mstatus_o,
  output logic [XLEN-1:0] sstatus_o,
  output logic [XLEN-1:0] isa_o,
  output logic            flush_o
);
  logic wr_m, wr_s, wr_isa;

  assign wr_m   = wr_en && (sel == SEL_MSTAT);
  assign wr_s   = wr_en && (sel == SEL_SVIEW);
  assign wr_isa = wr_en && (sel == SEL_ISA);

  mstat_unit #(.XLEN(XLEN)) u_mstat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_m    (wr_m),
    .wr_s    (wr_s),
    .wdata   (wr_data),
    .mstatus (mstatus_o),
    .sstatus (sstatus_o),
    .flush   (flush_o)
  );

  isa_unit #(.XLEN(XLEN), .SUPPORTED(SUPPORTED)) u_isa (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (wr_isa),
    .wdata       (wr_data),
    .next_pc_lsb (next_pc_lsb),
    .isa         (isa_o)
  );

  assert_onehot_sel_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_m, wr_s, wr_isa}));
endmodule

// File: tb/mstatus_isa_warl_test.sv
module mstatus_isa_warl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  next_pc_lsb = 2'b00;
  logic [31:0] mstatus_o, sstatus_o, isa_o;
  logic        flush_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] ms;
    logic [31:0] ss;
    logic [31:0] isa;
    logic        fl;
    string       req;
  } exp_t;
  exp_t q[$];

  logic [31:0] m_ms = 32'h0;
  logic [31:0] m_isa = 32'h4014112D;

  mstatus_isa_warl uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .next_pc_lsb(next_pc_lsb), .mstatus_o(mstatus_o), .sstatus_o(sstatus_o),
    .isa_o(isa_o), .flush_o(flush_o)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] st_legal(logic [31:0] old, logic [31:0] d);
    logic [31:0] n;
    n = (old & ~32'h007E79AA) | (d & 32'h007E79AA);
    n[31] = (n[14:13] == 2'b11) || (n[16:15] == 2'b11);
    return n;
  endfunction

  function automatic logic [31:0] isa_legal(logic [31:0] old, logic [31:0] d, logic [1:0] pc);
    logic [31:0] v;
    if (d[4] || !d[8]) return old;
    v = d & 32'h0014112D & 32'h0014113D;
    if (v[3] && !v[5]) v[3] = 1'b0;
    if (v[2] && pc != 2'b00) v[2] = 1'b0;
    return {old[31:30], v[29:0]};
  endfunction

  task automatic push(logic fl, string req);
    exp_t e;
    e.ms = m_ms; e.ss = m_ms & 32'h800DE133; e.isa = m_isa; e.fl = fl; e.req = req;
    q.push_back(e);
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d, logic [1:0] pc, string req);
    logic [31:0] old;
    logic fl;
    @(negedge clk);
    sel = s; wr_data = d; next_pc_lsb = pc; wr_en = 1'b1;
    old = m_ms; fl = 1'b0;
    if (s == 2'd0) m_ms = st_legal(m_ms, d);
    else if (s == 2'd1) m_ms = st_legal(m_ms, (m_ms & ~32'h800DE133) | (d & 32'h800DE133));
    else if (s == 2'd2) m_isa = isa_legal(m_isa, d, pc);
    if (s < 2'd2) fl = ((old ^ m_ms) & 32'h000E1800) != 0;
    @(posedge clk); #1;
    push(fl, req);
  endtask

  task automatic idle(string req);
    @(negedge clk);
    wr_en = 1'b0; wr_data = 32'hFFFFFFFF; sel = 2'd0;
    @(posedge clk); #1;
    push(1'b0, req);
  endtask

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.req, "mstatus", mstatus_o, e.ms);
      cmp(e.req, "sstatus", sstatus_o, e.ss);
      cmp(e.req, "isa", isa_o, e.isa);
      cmp(e.req, "flush", {31'b0, flush_o}, {31'b0, e.fl});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<5000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push(1'b0, "R1 reset");
    // status path
    wr(2'd0, 32'hFFFFFFFF, 2'b00, "R2 R3 R4 all-ones status");
    idle("R12 R4 hold after write");
    wr(2'd0, 32'h00002000, 2'b00, "R2 R3 R4 clear fields");
    wr(2'd0, 32'h00000008, 2'b00, "R3 R4 no-xlate change");
    wr(2'd0, 32'h00018000, 2'b00, "R2 R3 XS not writable");
    wr(2'd0, 32'h00001800, 2'b00, "R4 MPP change");
    wr(2'd0, 32'h00001800, 2'b00, "R4 same value no pulse");
    // supervisor view
    wr(2'd0, 32'h0, 2'b00, "R2 clear");
    wr(2'd1, 32'hFFFFFFFF, 2'b00, "R5 R6 supervisor all-ones");
    wr(2'd1, 32'h00000000, 2'b00, "R5 R6 supervisor clear keeps M fields");
    wr(2'd0, 32'h007E79AA, 2'b00, "R2 R5 view masks M fields");
    wr(2'd3, 32'h00000000, 2'b00, "R12 unused select");
    idle("R12 strobe low");
    // ISA path
    wr(2'd2, 32'h00000000, 2'b00, "R7 no base dropped");
    wr(2'd2, 32'h00000110, 2'b00, "R7 E set dropped");
    wr(2'd2, 32'h00001100, 2'b00, "R8 I and M only");
    wr(2'd2, 32'h00000108, 2'b00, "R9 D without F");
    wr(2'd2, 32'h3FFFFFEF, 2'b00, "R8 all legal letters");
    wr(2'd2, 32'h3FFFFFEF, 2'b10, "R10 misaligned drops C");
    wr(2'd2, 32'h0000012C, 2'b01, "R10 R9 misaligned with D and F");
    wr(2'd2, 32'h80000100, 2'b00, "R11 width field kept");
    wr(2'd2, 32'hC0000004, 2'b00, "R7 R11 no base with width bits");
    idle("R12 final hold");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule